// File: doc/BRIEF.md
# Dual-Channel Bus-Master Control Register Block

This block holds the byte-wide control and status registers of a two-channel disk bus-master controller. It also folds the two per-channel interrupt requests into one level-sensitive interrupt line. A 16-byte I/O window is decoded through a simple byte port. Address bit 3 selects the channel, so channel 1 sits 8 bytes above channel 0. Address bits 1:0 select a register inside the channel: 0 is command, 1 is the shared mode register, 2 is status and 3 is the per-channel timing register. Offsets 4 to 7 of each channel belong to descriptor-pointer logic that lives elsewhere. Here they read as zero and ignore writes. Reads are combinational and writes take effect at the next rising clock edge.

The shared mode register has one interrupt-pending flag per channel, in bits 2 and 3. These follow the channel interrupt inputs one cycle late. It also has one interrupt-block flag per channel, in bits 4 and 5, and software can write only these. The DMA engine raises status bits through strobe inputs.

Each channel's transfer-active flag is a two-state machine. In XFER_IDLE the flag reads 0, and in XFER_BUSY it reads 1. The transition GO (XFER_IDLE to XFER_BUSY) is taken when the engine's active strobe is high. The transition HALT (XFER_BUSY to XFER_IDLE) is taken when software writes the command register with start = 0 and no active strobe arrives in the same cycle. In every other case the state holds.

Top module: `bmr_regfile`

## Requirements
- R1: Offset 3 reaches timing register 0 through addresses 0x0–0x7 and timing register 1 through 0x8–0xF. Each is a full 8-bit read/write register, independent of the other.
- R2: A write to offset 1 through either channel (address 0x1 or 0x9) changes only mode bits 5:4, which are taken from write data bits 5:4. Both addresses read the same mode byte.
- R3: A status write (offset 2) stores data bits 6:5. It leaves bit 0 (active) unchanged, and bits 7, 4 and 3 always read 0.
- R4: In a status write, bits 1 (error) and 2 (interrupt) are cleared where the data holds a 1 and kept where it holds a 0.
- R5: Mode bit 2+n equals the level of channel n's interrupt input as sampled at the previous rising edge.
- R6: irq_out is high exactly when, for some channel n, mode bit 2+n is 1 and mode bit 4+n is 0.
- R7: The command register keeps only data bits 0 (start) and 3 (direction), and the other bits read 0. A command write with bit 0 = 0 clears that channel's active bit.
- R8: The strobes dma_set_act, dma_set_err and dma_set_int set status bits 0, 1 and 2 of their channel. If a strobe meets a software clear of the same bit in the same cycle, the bit ends up set.
- R9: While rst_n is low, every register reads 0 and irq_out is 0.
- R10: Offsets 4 to 7 of either channel read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 4 | Byte address in the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| chan_irq | input | 2 | Per-channel interrupt request levels |
| dma_set_act | input | 2 | Per-channel strobe that sets the active bit |
| dma_set_err | input | 2 | Per-channel strobe that sets the error bit |
| dma_set_int | input | 2 | Per-channel strobe that sets the interrupt bit |
| irq_out | output | 1 | Combined level interrupt |

## Verification
Software writes and engine strobes can hit the same status bit in the same cycle. This happens in two places. The active strobe can arrive alongside a command write that clears start. The error strobe can arrive alongside a status write of one to that bit. The bench drives both pairs at the same rising edge and expects the bit to read 1 afterwards. It also sweeps every status data byte after the engine has set error and interrupt, which checks the keep/clear mix arithmetically. The block flags and the interrupt inputs are swept through all 16 combinations to check the masked interrupt.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
    localparam int BMR_DW   = 8;
    localparam int BMR_CH   = 2;
    localparam int BMR_CH_W = (BMR_CH > 1) ? $clog2(BMR_CH) : 1;
    localparam int BMR_AW   = BMR_CH_W + 3;

    // bit positions that software decodes
    localparam int PEND_LSB  = 2;
    localparam int BLK_LSB   = 4;
    localparam int ST_ACT    = 0;
    localparam int ST_ERR    = 1;
    localparam int ST_INT    = 2;
    localparam int ST_KEEP_L = 5;
    localparam int ST_KEEP_W = 2;
    localparam int CMD_START = 0;
    localparam logic [BMR_DW-1:0] CMD_MASK = 8'h09;

    typedef enum logic [1:0] {
        REG_CMD  = 2'd0,
        REG_MODE = 2'd1,
        REG_STAT = 2'd2,
        REG_TIM  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        XFER_IDLE = 1'b0,
        XFER_BUSY = 1'b1
    } xfer_state_e;
endpackage

// File: rtl/bmr_chan.sv
module bmr_chan
    import bmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_stat,
    input  logic              wr_tim,
    input  logic [BMR_DW-1:0] wdata,
    input  logic              set_act,
    input  logic              set_err,
    input  logic              set_int,
    output logic [BMR_DW-1:0] cmd_q,
    output logic [BMR_DW-1:0] stat_q,
    output logic [BMR_DW-1:0] tim_q
);
    xfer_state_e          st_q, st_d;
    logic                 halt_req;
    logic                 err_q, int_q;
    logic [ST_KEEP_W-1:0] keep_q;

    assign halt_req = wr_cmd & ~wdata[CMD_START];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= XFER_IDLE;
        else        st_q <= st_d;
    end

    // next state: GO on engine strobe, HALT on stop unless strobe wins
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            XFER_IDLE: if (set_act)              st_d = XFER_BUSY;
            XFER_BUSY: if (halt_req && !set_act) st_d = XFER_IDLE;
            default:                             st_d = XFER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            tim_q  <= '0;
            err_q  <= 1'b0;
            int_q  <= 1'b0;
            keep_q <= '0;
        end else begin
            if (wr_cmd)  cmd_q  <= wdata & CMD_MASK;
            if (wr_tim)  tim_q  <= wdata;
            if (wr_stat) keep_q <= wdata[ST_KEEP_L +: ST_KEEP_W];
            err_q <= set_err | (err_q & ~(wr_stat & wdata[ST_ERR]));
            int_q <= set_int | (int_q & ~(wr_stat & wdata[ST_INT]));
        end
    end

    // output assembly
    always_comb begin
        stat_q                          = '0;
        stat_q[ST_ACT]                  = (st_q == XFER_BUSY);
        stat_q[ST_ERR]                  = err_q;
        stat_q[ST_INT]                  = int_q;
        stat_q[ST_KEEP_L +: ST_KEEP_W]  = keep_q;
    end
endmodule

// File: rtl/bmr_mode.sv
module bmr_mode
    import bmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_blk,
    input  logic [BMR_DW-1:0] wdata,
    input  logic [BMR_CH-1:0] chan_irq,
    output logic [BMR_DW-1:0] mode_q,
    output logic              irq_out
);
    logic [BMR_CH-1:0] pend_q, blk_q, chan_req;

    for (genvar n = 0; n < BMR_CH; n++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[n] <= 1'b0;
                blk_q[n]  <= 1'b0;
            end else begin
                pend_q[n] <= chan_irq[n];
                if (wr_blk) blk_q[n] <= wdata[BLK_LSB + n];
            end
        end
        assign chan_req[n] = pend_q[n] & ~blk_q[n];
    end

    assign irq_out = |chan_req;

    always_comb begin
        mode_q                       = '0;
        mode_q[PEND_LSB +: BMR_CH]   = pend_q;
        mode_q[BLK_LSB  +: BMR_CH]   = blk_q;
    end
endmodule

// File: rtl/bmr_regfile.sv
module bmr_regfile
    import bmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BMR_AW-1:0] addr,
    input  logic [BMR_DW-1:0] wdata,
    output logic [BMR_DW-1:0] rdata,
    input  logic [BMR_CH-1:0] chan_irq,
    input  logic [BMR_CH-1:0] dma_set_act,
    input  logic [BMR_CH-1:0] dma_set_err,
    input  logic [BMR_CH-1:0] dma_set_int,
    output logic              irq_out
);
    logic [BMR_CH_W-1:0]           ch_sel;
    logic                          hi_half;
    reg_sel_e                      sel;
    logic [BMR_DW-1:0]             mode_q;
    logic [BMR_CH-1:0][BMR_DW-1:0] cmd_q, stat_q, tim_q;
    logic                          wr_blk;

    assign ch_sel  = addr[BMR_AW-1:3];
    assign hi_half = addr[2];
    assign sel     = reg_sel_e'(addr[1:0]);
    assign wr_blk  = wr_en & ~hi_half & (sel == REG_MODE);

    for (genvar n = 0; n < BMR_CH; n++) begin : g_chan
        logic hit;
        assign hit = wr_en & ~hi_half & (ch_sel == BMR_CH_W'(n));
        bmr_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_cmd  (hit & (sel == REG_CMD)),
            .wr_stat (hit & (sel == REG_STAT)),
            .wr_tim  (hit & (sel == REG_TIM)),
            .wdata   (wdata),
            .set_act (dma_set_act[n]),
            .set_err (dma_set_err[n]),
            .set_int (dma_set_int[n]),
            .cmd_q   (cmd_q[n]),
            .stat_q  (stat_q[n]),
            .tim_q   (tim_q[n])
        );
    end

    bmr_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_blk   (wr_blk),
        .wdata    (wdata),
        .chan_irq (chan_irq),
        .mode_q   (mode_q),
        .irq_out  (irq_out)
    );

    always_comb begin
        rdata = '0;
        if (!hi_half) begin
            unique case (sel)
                REG_CMD:  rdata = cmd_q[ch_sel];
                REG_MODE: rdata = mode_q;
                REG_STAT: rdata = stat_q[ch_sel];
                REG_TIM:  rdata = tim_q[ch_sel];
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/bmr_regfile_chk.sv
module bmr_regfile_chk
    import bmr_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [BMR_AW-1:0]             addr,
    input logic [BMR_DW-1:0]             wdata,
    input logic [BMR_CH-1:0]             chan_irq,
    input logic [BMR_CH-1:0]             dma_set_act,
    input logic [BMR_CH-1:0]             dma_set_err,
    input logic                          irq_out,
    input logic [BMR_DW-1:0]             mode_q,
    input logic [BMR_CH-1:0][BMR_DW-1:0] stat_q
);
    AST_PEND_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> mode_q[PEND_LSB +: BMR_CH] == $past(chan_irq)); // R5

    AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !addr[2] && addr[1:0] == 2'd1) |=> $stable(mode_q[BLK_LSB +: BMR_CH])); // R2

    AST_ERR_SET_WINS0: assert property (@(posedge clk) disable iff (!rst_n)
        dma_set_err[0] |=> stat_q[0][ST_ERR]); // R8

    AST_ERR_SET_WINS1: assert property (@(posedge clk) disable iff (!rst_n)
        dma_set_err[1] |=> stat_q[1][ST_ERR]); // R8

    AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && !wdata[CMD_START] && !dma_set_act[0]) |=> !stat_q[0][ST_ACT]); // R7

    AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[BLK_LSB +: BMR_CH] == '1) |-> !irq_out); // R6

    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[PEND_LSB] && !mode_q[BLK_LSB]) |-> irq_out); // R6
endmodule

bind bmr_regfile bmr_regfile_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .chan_irq    (chan_irq),
    .dma_set_act (dma_set_act),
    .dma_set_err (dma_set_err),
    .irq_out     (irq_out),
    .mode_q      (mode_q),
    .stat_q      (stat_q)
);

// File: tb/bmr_regfile_tb.sv
module bmr_regfile_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] chan_irq = '0;
    logic [1:0] dma_set_act = '0;
    logic [1:0] dma_set_err = '0;
    logic [1:0] dma_set_int = '0;
    logic       irq_out;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    bmr_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .chan_irq(chan_irq), .dma_set_act(dma_set_act),
        .dma_set_err(dma_set_err), .dma_set_int(dma_set_int), .irq_out(irq_out)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #1;
        chk(rdata, exp, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        for (int a = 0; a < 16; a++) rd(4'(a), 8'h00, "R9 reset read");
        chk({7'd0, irq_out}, 8'h00, "R9 reset irq");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: timing registers, both channels independent
        for (int v = 0; v < 256; v++) begin
            wr(4'h3, 8'(v));
            wr(4'hB, ~8'(v));
            rd(4'h3, 8'(v), "R1 timing0");
            rd(4'hB, ~8'(v), "R1 timing1");
        end

        // R2: shared mode register, only block bits writable
        for (int v = 0; v < 256; v++) begin
            wr((v % 2) ? 4'h9 : 4'h1, 8'(v));
            rd(4'h1, 8'(v) & 8'h30, "R2 mode via ch0");
            rd(4'h9, 8'(v) & 8'h30, "R2 mode via ch1");
        end
        wr(4'h1, 8'h00);

        // R3 R4: status write after engine set error+interrupt
        for (int c = 0; c < 2; c++) begin
            for (int v = 0; v < 256; v++) begin
                @(negedge clk);
                dma_set_err[c] = 1'b1; dma_set_int[c] = 1'b1;
                @(negedge clk);
                dma_set_err = '0; dma_set_int = '0;
                wr(c ? 4'hA : 4'h2, 8'(v));
                rd(c ? 4'hA : 4'h2, (8'(v) & 8'h60) | (8'h06 & ~8'(v)), "R3 R4 status write");
            end
            wr(c ? 4'hA : 4'h2, 8'h06);
            rd(c ? 4'hA : 4'h2, 8'h00, "R4 status cleared");
        end

        // R5 R6: pending tracking and masked interrupt
        for (int b = 0; b < 4; b++) begin
            for (int p = 0; p < 4; p++) begin
                wr(4'h1, 8'(b << 4));
                chan_irq = 2'(p);
                @(negedge clk);
                rd(4'h1, 8'((b << 4) | (p << 2)), "R5 pending bits");
                chk({7'd0, irq_out}, {7'd0, |(2'(p) & ~2'(b))}, "R6 irq level");
            end
        end
        chan_irq = '0;
        wr(4'h1, 8'h00);
        @(negedge clk);
        chk({7'd0, irq_out}, 8'h00, "R6 irq low");

        // R7: command bits and halt
        for (int c = 0; c < 2; c++) begin
            wr(c ? 4'h8 : 4'h0, 8'hFF);
            rd(c ? 4'h8 : 4'h0, 8'h09, "R7 cmd keeps start/dir");
            wr(c ? 4'h8 : 4'h0, 8'hF6);
            rd(c ? 4'h8 : 4'h0, 8'h00, "R7 cmd other bits");
        end
        @(negedge clk); dma_set_act[0] = 1'b1;
        @(negedge clk); dma_set_act = '0;
        rd(4'h2, 8'h01, "R8 active set");
        rd(4'hA, 8'h00, "R8 other channel untouched");
        wr(4'h0, 8'h01);
        rd(4'h2, 8'h01, "R7 start kept active");
        wr(4'h2, 8'h00);
        rd(4'h2, 8'h01, "R3 status write keeps active");
        wr(4'h0, 8'h08);
        rd(4'h2, 8'h00, "R7 halt clears active");

        // R8: same-cycle set and clear
        @(negedge clk);
        addr = 4'h0; wdata = 8'h00; wr_en = 1'b1; dma_set_act[0] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; dma_set_act = '0;
        rd(4'h2, 8'h01, "R8 act set beats halt");
        @(negedge clk);
        addr = 4'hA; wdata = 8'h62; wr_en = 1'b1; dma_set_err[1] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; dma_set_err = '0;
        rd(4'hA, 8'h62, "R8 err set beats clear");

        // R10: hidden offsets
        wr(4'h3, 8'h5A); wr(4'hB, 8'hA5);
        for (int a = 4; a < 8; a++) begin
            wr(4'(a), 8'hFF); wr(4'(a + 8), 8'hFF);
        end
        for (int a = 4; a < 8; a++) begin
            rd(4'(a), 8'h00, "R10 hidden ch0");
            rd(4'(a + 8), 8'h00, "R10 hidden ch1");
        end
        rd(4'h0, 8'h00, "R10 cmd untouched");
        rd(4'h1, 8'h00, "R10 mode untouched");
        rd(4'h2, 8'h01, "R10 status untouched");
        rd(4'h3, 8'h5A, "R10 timing0 untouched");
        rd(4'hB, 8'hA5, "R10 timing1 untouched");

        // R9: reset mid-run
        wr(4'h8, 8'h09);
        chan_irq = 2'b10;
        @(negedge clk);
        chk({7'd0, irq_out}, 8'h01, "R6 irq before reset");
        rst_n = 1'b0;
        chan_irq = '0;
        #1;
        for (int a = 0; a < 16; a++) rd(4'(a), 8'h00, "R9 reset clears");
        chk({7'd0, irq_out}, 8'h00, "R9 reset irq low");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule